// File: doc/BRIEF.md
# Ratio Clock Divider with Coincidence Sync

This block divides one fast source clock into three output banks (A, B and C). The banks run at integer or non-integer related rates such as 3:2 or 4:3, and their ratios come from a 4-bit select word. The select word is captured only while the synchronous master reset is held. Every bank output is a registered, glitch-free level that toggles on source clock edges. The block can serve as the divider stage behind a PLL, or it can be stepped edge by edge from a test clock. In the test-clock case, one output transition can take several source edges.

A sync output marks the common period of banks A and C. It is a single source-cycle pulse, placed in the cycle just before bank A and bank C rise together. This lets downstream logic find the aligned edge of two clocks whose ratio is not a power of two. A fourth output, bank D, carries either that sync pulse or a copy of bank C, as chosen by a live select input. After reset is released, all three banks rise on the same source edge. Reset therefore realigns every divider after the ratio word is changed.

Top module: `ratio_clk_div`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the outputs `qa`, `qb`, `qc`, `qd` and `sync` are low after that edge and stay low until the first edge with `rst` low.
- R2: The value on `ratio_sel` at the last reset edge chooses the divides (A/B/C) as follows: 0:2/2/2, 1:4/4/4, 2:2/4/4, 3:2/2/4, 4:2/6/6, 5:2/2/6, 6:4/6/6, 7:2/3/3, 8:2/8/8, 9:2/2/8, 10:6/8/8, 11:3/4/4, 12:3/4/12, 13:3/4/6, 14:6/6/4, 15:8/8/6.
- R3: A bank with an even divide d is high for d/2 source cycles and then low for d/2 source cycles.
- R4: A bank with divide 3 is high for 2 source cycles and then low for 1 source cycle.
- R5: After the first clock edge following reset release, `qa`, `qb` and `qc` are all high. Counting that edge as n=1, a bank with divide d is high after edge n exactly when (n-1) mod d < (d+1)/2 (integer division).
- R6: `sync` is high after edge n exactly when n mod L = 0, where L is the least common multiple of the A and C divides. It is therefore one cycle wide and sits just before each common rising edge of `qa` and `qc`.
- R7: `qd` follows `sync` while `sync_sel` is 1 and follows `qc` while `sync_sel` is 0. The selection responds to `sync_sel` without waiting for a clock edge.
- R8: Changes on `ratio_sel` while `rst` is low have no effect on any output until the next reset.
- R9: Once running, each bank rises exactly once every d source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock (PLL output or test clock) |
| rst | input | 1 | Synchronous master reset, active high; also captures `ratio_sel` |
| ratio_sel | input | 4 | Ratio configuration code |
| sync_sel | input | 1 | Bank D source: 1 = sync pulse, 0 = bank C copy |
| qa | output | 1 | Bank A divided clock |
| qb | output | 1 | Bank B divided clock |
| qc | output | 1 | Bank C divided clock |
| qd | output | 1 | Bank D: sync pulse or bank C copy |
| sync | output | 1 | One-cycle pulse before each common A/C rising edge |

## Verification
The hardest condition to reach is the wrap of the longest common period. For codes 10 and 15, banks A and C meet only every 24 source cycles. The sync pulse there depends on three counters agreeing after many cycles of misalignment. The stimulus resets into each of the 16 codes and runs 40 cycles, which covers at least one full 24-cycle common period plus the alignment that follows. Partway through each run it drives a different ratio code to show that nothing moves, and it flips the bank D select to exercise both mux paths in the same configuration.

// File: rtl/ratio_clk_div.sv
`timescale 1ns/1ps
module ratio_clk_div #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] ratio_sel,
  input  logic       sync_sel,
  output logic       qa,
  output logic       qb,
  output logic       qc,
  output logic       qd,
  output logic       sync
);

  localparam int NBANK = 3;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef cnt_t [NBANK:0] cfg_t;

  function automatic cfg_t mk(input int a, input int b, input int c, input int l);
    cfg_t r;
    r[0] = cnt_t'(a);
    r[1] = cnt_t'(b);
    r[2] = cnt_t'(c);
    r[3] = cnt_t'(l);
    return r;
  endfunction

  // entry: divide A, divide B, divide C, lcm(A,C)
  function automatic cfg_t ratio_table(input logic [3:0] s);
    cfg_t r;
    case (s)
      4'd0:    r = mk(2, 2, 2, 2);
      4'd1:    r = mk(4, 4, 4, 4);
      4'd2:    r = mk(2, 4, 4, 4);
      4'd3:    r = mk(2, 2, 4, 4);
      4'd4:    r = mk(2, 6, 6, 6);
      4'd5:    r = mk(2, 2, 6, 6);
      4'd6:    r = mk(4, 6, 6, 12);
      4'd7:    r = mk(2, 3, 3, 6);
      4'd8:    r = mk(2, 8, 8, 8);
      4'd9:    r = mk(2, 2, 8, 8);
      4'd10:   r = mk(6, 8, 8, 24);
      4'd11:   r = mk(3, 4, 4, 12);
      4'd12:   r = mk(3, 4, 12, 12);
      4'd13:   r = mk(3, 4, 6, 6);
      4'd14:   r = mk(6, 6, 4, 12);
      default: r = mk(8, 8, 6, 24);
    endcase
    return r;
  endfunction

  logic [3:0]       code_q;
  cfg_t             cfg;
  logic [NBANK-1:0] bank_q;
  cnt_t             cc;
  logic             sync_q;

  always_ff @(posedge clk)
    if (rst) code_q <= ratio_sel;

  assign cfg = ratio_table(code_q);

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    cnt_t d, half, ph;
    logic q;
    assign d    = cfg[i];
    assign half = (d + cnt_t'(1)) >> 1;

    always_ff @(posedge clk)
      if (rst) begin
        ph <= '0;
        q  <= 1'b0;
      end else begin
        q  <= ph < half;
        ph <= (ph == d - cnt_t'(1)) ? '0 : ph + cnt_t'(1);
      end

    assign bank_q[i] = q;

    logic q_d, seen;
    cnt_t gap;
    always_ff @(posedge clk)
      if (rst) begin
        q_d  <= 1'b0;
        seen <= 1'b0;
        gap  <= '0;
      end else begin
        q_d <= q;
        if (q && !q_d) begin
          seen <= 1'b1;
          gap  <= cnt_t'(1);
        end else if (gap != '1) begin
          gap <= gap + cnt_t'(1);
        end
      end

    a_r9_rise_period: assert property (@(posedge clk) disable iff (rst)
      (seen && q && !q_d) |-> gap == d);
  end

  always_ff @(posedge clk)
    if (rst) begin
      cc     <= '0;
      sync_q <= 1'b0;
    end else begin
      sync_q <= cc == cfg[3] - cnt_t'(1);
      cc     <= (cc == cfg[3] - cnt_t'(1)) ? '0 : cc + cnt_t'(1);
    end

  assign qa   = bank_q[0];
  assign qb   = bank_q[1];
  assign qc   = bank_q[2];
  assign sync = sync_q;
  assign qd   = sync_sel ? sync_q : bank_q[2];

  a_r1_quiet_at_release: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bank_q == '0 && !sync_q));

  a_r5_aligned_start: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (qa && qb && qc));

  a_r6_sync_single: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> !sync_q);

  a_r6_sync_before_edge: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> ($rose(qa) && $rose(qc)));

  a_r8_code_held: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(code_q));

endmodule

// File: tb/ratio_clk_div_tb.sv
`timescale 1ns/1ps
module ratio_clk_div_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] sel = 4'd0;
  logic ssel = 1'b0;
  logic qa, qb, qc, qd, sync;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ratio_clk_div u_dut (
    .clk(clk), .rst(rst), .ratio_sel(sel), .sync_sel(ssel),
    .qa(qa), .qb(qb), .qc(qc), .qd(qd), .sync(sync)
  );

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // R2 mapping as stated in the requirement
  function automatic void lut(input int c, output int a, output int b, output int d);
    case (c)
      0: begin a = 2; b = 2; d = 2; end
      1: begin a = 4; b = 4; d = 4; end
      2: begin a = 2; b = 4; d = 4; end
      3: begin a = 2; b = 2; d = 4; end
      4: begin a = 2; b = 6; d = 6; end
      5: begin a = 2; b = 2; d = 6; end
      6: begin a = 4; b = 6; d = 6; end
      7: begin a = 2; b = 3; d = 3; end
      8: begin a = 2; b = 8; d = 8; end
      9: begin a = 2; b = 2; d = 8; end
      10: begin a = 6; b = 8; d = 8; end
      11: begin a = 3; b = 4; d = 4; end
      12: begin a = 3; b = 4; d = 12; end
      13: begin a = 3; b = 4; d = 6; end
      14: begin a = 6; b = 6; d = 4; end
      default: begin a = 8; b = 8; d = 6; end
    endcase
  endfunction

  function automatic int gcd(input int x, input int y);
    int p = x, q = y;
    while (q != 0) begin
      int t = p % q;
      p = q;
      q = t;
    end
    return p;
  endfunction

  function automatic logic lvl(input int n, input int d);
    return ((n - 1) % d) < ((d + 1) / 2);
  endfunction

  function automatic string tag(input int n, input int d, input bit moved);
    if (moved) return "R8";
    if (n == 1) return "R5";
    if (d == 3) return "R4";
    return "R3";
  endfunction

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int code = 0; code < 16; code++) begin
      int da, db, dc, l;
      bit moved;
      lut(code, da, db, dc);
      l = da * dc / gcd(da, dc);
      moved = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      sel = 4'(code);
      ssel = code[0];
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        // R1 outputs held low during reset
        chk("R1", "qa", qa, 1'b0);
        chk("R1", "qb", qb, 1'b0);
        chk("R1", "qc", qc, 1'b0);
        chk("R1", "sync", sync, 1'b0);
        chk("R1", "qd", qd, 1'b0);
      end
      rst = 1'b0;
      for (int n = 1; n <= 40; n++) begin
        @(negedge clk);
        // R2 and R9 are covered by the per-code divide and period in lvl()
        chk(tag(n, da, moved), "qa", qa, lvl(n, da));
        chk(tag(n, db, moved), "qb", qb, lvl(n, db));
        chk(tag(n, dc, moved), "qc", qc, lvl(n, dc));
        chk(moved ? "R8" : "R6", "sync", sync, (n % l) == 0);
        chk("R7", "qd", qd, ssel ? ((n % l) == 0) : lvl(n, dc));
        if (n == 12) begin
          sel = 4'(15 - code);
          moved = 1'b1;
        end
        if (n == 20) ssel = ~ssel;
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule